// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block keeps the mode settings of a DRAM-style memory device and, for each burst, works out the order in which column addresses are visited. A 13-bit mode word arrives with a load strobe and a 2-bit bank-select value. Only a bank-select of zero writes the base mode register. The stored word is decoded into four settings: burst length, burst ordering, CAS latency and operating mode. Each field that holds a reserved code raises a common error flag.

A start strobe comes with a starting column. When it is accepted, the block presents one column address per clock together with a beat-valid flag, and it marks the final beat with a last flag. The columns stay inside an aligned block whose size equals the burst length. Within that block they follow either an upward count that wraps at the block edge, or an exclusive-OR pattern of the start and the beat index. Burst length and ordering are captured when the burst starts, so loading a new mode word in the middle of a burst does not change that burst.

Top module: `burst_col_seq`

## Requirements
- R1: A load strobe writes `mode_addr` into the base mode register only when `mode_ba` is 2'b00. With any other `mode_ba` the register and all `cfg_*` outputs keep their values.
- R2: Mode bits [2:0] set the burst length. 3'b001 gives `cfg_burst_len`=2, 3'b010 gives 4, 3'b011 gives 8. Every other code gives `cfg_burst_len`=0 and is reserved.
- R3: Mode bit [3] sets the ordering. 0 is sequential (`cfg_interleave`=0) and 1 is interleaved (`cfg_interleave`=1).
- R4: Mode bits [6:4] set the CAS latency, reported in half cycles on `cfg_cas_x2`. 3'b010 gives 4 (latency 2), 3'b110 gives 5 (latency 2.5). Every other code gives 0 and is reserved.
- R5: Mode bits [12:7] set the operating mode. All zero is normal operation. 6'b000010 (only bit 8 set) is normal operation with `cfg_dll_reset`=1. Every other value is reserved.
- R6: `cfg_error` is 1 while any field of the stored mode word is reserved. A start strobe sampled while `cfg_error` is 1 produces no beats.
- R7: For a burst of length N, every beat keeps the bits of `start_col` above bit log2(N)-1 unchanged.
- R8: In sequential order, the low log2(N) bits of beat i equal (start + i) mod N. For example, start 5 at length 8 gives 5,6,7,0,1,2,3,4.
- R9: In interleaved order, the low log2(N) bits of beat i equal start XOR i. For example, start 5 at length 8 gives 5,4,7,6,1,0,3,2.
- R10: If a start is accepted at a clock edge, beat 0 is on the outputs after that edge. Each following edge presents the next beat. `beat_last` is 1 with the Nth beat, and `beat_valid` falls at the next edge unless a new start is accepted there.
- R11: A start strobe sampled while a burst is running and the current beat is not the last one is ignored. A start sampled while the last beat is on the outputs is accepted, and its beat 0 follows directly.
- R12: Burst length and ordering are captured when a burst is accepted. A mode load during the burst does not alter its length or order.
- R13: After reset the decoded settings are length 2, sequential, CAS latency 2, normal operation and no error, and `beat_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Mode register load strobe |
| mode_ba | input | 2 | Bank-select value; 0 addresses the base register |
| mode_addr | input | 13 | Mode word |
| start | input | 1 | Burst start strobe |
| start_col | input | COL_W | Starting column address |
| col_out | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is presented |
| beat_last | output | 1 | The current beat is the final one |
| cfg_burst_len | output | 4 | Decoded burst length, 0 if reserved |
| cfg_interleave | output | 1 | 1 for interleaved order |
| cfg_cas_x2 | output | 3 | CAS latency in half cycles, 0 if reserved |
| cfg_dll_reset | output | 1 | Operating mode requests a DLL reset |
| cfg_error | output | 1 | Some field of the stored mode word is reserved |

## Verification
The decoded settings reflect a load one edge after the strobe is sampled, so they are read at the falling edge after that load edge. Beat 0 appears one edge after an accepted start, and each later beat one edge after the one before it. The bench holds a queue-based model that steps on the rising edge with the same inputs. It compares every output at each falling edge, when both the model and the design have settled. Directed sequences with literal column values add checks on the wrap, the exclusive-OR order, back-to-back starts and the stability of a running burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int MODE_W = 13;
  localparam int BANK_W = 2;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_XOR = 1'b1
  } order_e;

  // Field layout of the stored mode word, most significant first
  typedef struct packed {
    logic [5:0] op_code;
    logic [2:0] cas_code;
    order_e     order;
    logic [2:0] len_code;
  } mode_word_t;

  localparam logic [MODE_W-1:0] MODE_RESET = 13'h021;

endpackage

// File: rtl/mode_store.sv
module mode_store
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [MODE_W-1:0] word_in,
  output mode_word_t        word_q
);

  logic base_hit;
  assign base_hit = load && (bank_sel == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= mode_word_t'(MODE_RESET);
    end else if (base_hit) begin
      word_q <= mode_word_t'(word_in);
    end
  end

endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import burst_seq_pkg::*;
(
  input  mode_word_t word,
  output logic [3:0] burst_len,
  output logic [1:0] len_log2,
  output logic       interleave,
  output logic [2:0] cas_x2,
  output logic       dll_reset,
  output logic       err
);

  logic len_bad, cas_bad, op_bad;

  always_comb begin
    len_bad  = 1'b0;
    case (word.len_code)
      3'b001:  begin burst_len = 4'd2; len_log2 = 2'd1; end
      3'b010:  begin burst_len = 4'd4; len_log2 = 2'd2; end
      3'b011:  begin burst_len = 4'd8; len_log2 = 2'd3; end
      default: begin burst_len = 4'd0; len_log2 = 2'd1; len_bad = 1'b1; end
    endcase
  end

  always_comb begin
    cas_bad = 1'b0;
    case (word.cas_code)
      3'b010:  cas_x2 = 3'd4;
      3'b110:  cas_x2 = 3'd5;
      default: begin cas_x2 = 3'd0; cas_bad = 1'b1; end
    endcase
  end

  always_comb begin
    op_bad    = 1'b0;
    dll_reset = 1'b0;
    case (word.op_code)
      6'b000000: ;
      6'b000010: dll_reset = 1'b1;
      default:   op_bad = 1'b1;
    endcase
  end

  assign interleave = (word.order == ORDER_XOR);
  assign err        = len_bad | cas_bad | op_bad;

endmodule

// File: rtl/burst_engine.sv
module burst_engine
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             allowed,
  input  logic [1:0]       len_log2,
  input  logic             interleave,
  output logic [COL_W-1:0] col_q,
  output logic             valid_q,
  output logic             last_q
);

  logic [COL_W-1:0] base_q;
  logic [IDX_W-1:0] mask_q, mask_c, idx_q;
  order_e           order_q;
  logic [IDX_W-1:0] low_base, f_seq, f_xor, f_sel, low_next;
  logic             busy, accept;

  always_comb begin
    mask_c = '0;
    for (int b = 0; b < IDX_W; b++) begin
      if (b < int'(len_log2)) mask_c[b] = 1'b1;
    end
  end

  assign low_base = base_q[IDX_W-1:0];
  assign f_seq    = low_base + idx_q;
  assign f_xor    = low_base ^ idx_q;
  assign f_sel    = (order_q == ORDER_XOR) ? f_xor : f_seq;

  // Bits inside the block follow the order, bits above it hold the start
  for (genvar b = 0; b < IDX_W; b++) begin : g_merge
    assign low_next[b] = mask_q[b] ? f_sel[b] : low_base[b];
  end

  assign busy   = valid_q && !last_q;
  assign accept = start && !busy && allowed;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      mask_q  <= '0;
      idx_q   <= '0;
      order_q <= ORDER_SEQ;
      col_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (accept) begin
      base_q  <= start_col;
      mask_q  <= mask_c;
      order_q <= interleave ? ORDER_XOR : ORDER_SEQ;
      idx_q   <= {{(IDX_W-1){1'b0}}, 1'b1};
      col_q   <= start_col;
      valid_q <= 1'b1;
      last_q  <= 1'b0;
    end else if (busy) begin
      col_q   <= {base_q[COL_W-1:IDX_W], low_next};
      last_q  <= (idx_q == mask_q);
      idx_q   <= idx_q + 1'b1;
    end else begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_load,
  input  logic [1:0]       mode_ba,
  input  logic [12:0]      mode_addr,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  output logic [COL_W-1:0] col_out,
  output logic             beat_valid,
  output logic             beat_last,
  output logic [3:0]       cfg_burst_len,
  output logic             cfg_interleave,
  output logic [2:0]       cfg_cas_x2,
  output logic             cfg_dll_reset,
  output logic             cfg_error
);

  localparam int IDX_W = 3;

  mode_word_t word_q;
  logic [1:0] len_log2;

  mode_store u_store (
    .clk      (clk),
    .rst      (rst),
    .load     (mode_load),
    .bank_sel (mode_ba),
    .word_in  (mode_addr),
    .word_q   (word_q)
  );

  mode_decode u_decode (
    .word       (word_q),
    .burst_len  (cfg_burst_len),
    .len_log2   (len_log2),
    .interleave (cfg_interleave),
    .cas_x2     (cfg_cas_x2),
    .dll_reset  (cfg_dll_reset),
    .err        (cfg_error)
  );

  burst_engine #(.COL_W(COL_W), .IDX_W(IDX_W)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_col  (start_col),
    .allowed    (!cfg_error),
    .len_log2   (len_log2),
    .interleave (cfg_interleave),
    .col_q      (col_out),
    .valid_q    (beat_valid),
    .last_q     (beat_last)
  );

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_load,
  input logic [1:0]       mode_ba,
  input logic             start,
  input logic [COL_W-1:0] col_out,
  input logic             beat_valid,
  input logic             beat_last,
  input logic [3:0]       cfg_burst_len,
  input logic             cfg_interleave,
  input logic [2:0]       cfg_cas_x2,
  input logic             cfg_dll_reset,
  input logic             cfg_error
);

  // R13
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cfg_burst_len == 4'd2 && !cfg_interleave && cfg_cas_x2 == 3'd4
             && !cfg_dll_reset && !cfg_error && !beat_valid));

  // R1
  bank_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_load && mode_ba != 2'b00) |=>
      ($stable(cfg_burst_len) && $stable(cfg_interleave) && $stable(cfg_cas_x2)
       && $stable(cfg_dll_reset) && $stable(cfg_error)));

  // R2
  len_code_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_burst_len == 4'd0) |-> cfg_error);

  // R4
  cas_code_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_cas_x2 == 3'd0) |-> cfg_error);

  // R6
  err_block_chk: assert property (@(posedge clk) disable iff (rst)
    (start && cfg_error && !(beat_valid && !beat_last)) |=> !beat_valid);

  // R10
  last_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid);

  // R7, R11
  burst_continue_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_last) |=>
      (beat_valid && col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .mode_load      (mode_load),
  .mode_ba        (mode_ba),
  .start          (start),
  .col_out        (col_out),
  .beat_valid     (beat_valid),
  .beat_last      (beat_last),
  .cfg_burst_len  (cfg_burst_len),
  .cfg_interleave (cfg_interleave),
  .cfg_cas_x2     (cfg_cas_x2),
  .cfg_dll_reset  (cfg_dll_reset),
  .cfg_error      (cfg_error)
);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mode_load = 1'b0;
  logic [1:0]       mode_ba = 2'b00;
  logic [12:0]      mode_addr = '0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [COL_W-1:0] col_out;
  logic             beat_valid, beat_last;
  logic [3:0]       cfg_burst_len;
  logic             cfg_interleave;
  logic [2:0]       cfg_cas_x2;
  logic             cfg_dll_reset, cfg_error;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_ba(mode_ba),
    .mode_addr(mode_addr), .start(start), .start_col(start_col),
    .col_out(col_out), .beat_valid(beat_valid), .beat_last(beat_last),
    .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
    .cfg_cas_x2(cfg_cas_x2), .cfg_dll_reset(cfg_dll_reset), .cfg_error(cfg_error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  bit    cmp_on = 0;
  string phase  = "R13";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [12:0] m_reg = 13'h021;
  int          q[$];
  bit          e_valid = 0, e_last = 0;
  int          e_col = 0;

  function automatic int m_len(input logic [12:0] m);
    case (m[2:0]) 3'b001: return 2; 3'b010: return 4; 3'b011: return 8; default: return 0; endcase
  endfunction
  function automatic int m_cas(input logic [12:0] m);
    case (m[6:4]) 3'b010: return 4; 3'b110: return 5; default: return 0; endcase
  endfunction
  function automatic bit m_opbad(input logic [12:0] m);
    return !(m[12:7] == 6'b000000 || m[12:7] == 6'b000010);
  endfunction
  function automatic bit m_err(input logic [12:0] m);
    return m_len(m) == 0 || m_cas(m) == 0 || m_opbad(m);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reg = 13'h021; q.delete(); e_valid = 0; e_last = 0; e_col = 0;
    end else begin
      if (start && !(e_valid && !e_last) && !m_err(m_reg)) begin
        int n, low, base;
        n    = m_len(m_reg);
        low  = int'(start_col) % n;
        base = int'(start_col) - low;
        for (int i = 0; i < n; i++)
          q.push_back(base + (m_reg[3] ? (low ^ i) : ((low + i) % n)));
      end
      if (mode_load && mode_ba == 2'b00) m_reg = mode_addr;
      if (q.size() > 0) begin
        e_col = q.pop_front(); e_valid = 1; e_last = (q.size() == 0);
      end else begin
        e_valid = 0; e_last = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check(beat_valid == e_valid, {phase, " valid"}, beat_valid, e_valid);
      if (e_valid) begin
        check(int'(col_out) == e_col, {phase, " col"}, col_out, e_col);
        check(beat_last == e_last, {phase, " last"}, beat_last, e_last);
      end
      check(int'(cfg_burst_len) == m_len(m_reg), "R2 len", cfg_burst_len, m_len(m_reg));
      check(cfg_interleave == m_reg[3], "R3 order", cfg_interleave, m_reg[3]);
      check(int'(cfg_cas_x2) == m_cas(m_reg), "R4 cas", cfg_cas_x2, m_cas(m_reg));
      check(cfg_dll_reset == (m_reg[12:7] == 6'b000010), "R5 dll", cfg_dll_reset,
            m_reg[12:7] == 6'b000010);
      check(cfg_error == m_err(m_reg), "R6 error", cfg_error, m_err(m_reg));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic load_mode(input logic [1:0] ba, input logic [12:0] w);
    @(negedge clk); mode_load = 1'b1; mode_ba = ba; mode_addr = w;
    @(negedge clk); mode_load = 1'b0; mode_ba = 2'b00;
  endtask

  // Drives a start and returns at the falling edge where beat 0 is shown
  task automatic kick(input int col);
    @(negedge clk); start = 1'b1; start_col = COL_W'(col);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic expect_burst(input int exp[8], input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(beat_valid == 1'b1, {req, " beat valid"}, beat_valid, 1);
      check(int'(col_out) == exp[i], {req, " beat col"}, col_out, exp[i]);
      check(beat_last == (i == n - 1), {req, " last flag"}, beat_last, i == n - 1);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset values
    check(cfg_burst_len == 4'd2, "R13 len", cfg_burst_len, 2);
    check(cfg_cas_x2 == 3'd4 && !cfg_interleave, "R13 cas/order", cfg_cas_x2, 4);
    check(!beat_valid && !cfg_error, "R13 idle", beat_valid, 0);
    cmp_on = 1;

    // R1: non-zero bank-select leaves the base register alone
    phase = "R1";
    load_mode(2'b01, 13'h033);
    check(cfg_burst_len == 4'd2, "R1 bank 1 ignored", cfg_burst_len, 2);
    load_mode(2'b10, 13'h1FF);
    check(cfg_error == 1'b0, "R1 bank 2 ignored", cfg_error, 0);

    // R2, R8, R7, R10: length 8 sequential wraps in its block
    phase = "R8";
    load_mode(2'b00, 13'h023);
    check(cfg_burst_len == 4'd8, "R2 length 8", cfg_burst_len, 8);
    kick(12'h3C5);
    expect_burst('{12'h3C5, 12'h3C6, 12'h3C7, 12'h3C0, 12'h3C1, 12'h3C2, 12'h3C3, 12'h3C4}, 8, "R8");
    check(beat_valid == 1'b0, "R10 valid drops", beat_valid, 0);

    // R3, R9: interleaved order
    phase = "R9";
    load_mode(2'b00, 13'h02B);
    check(cfg_interleave == 1'b1, "R3 interleave", cfg_interleave, 1);
    kick(12'h3C5);
    expect_burst('{12'h3C5, 12'h3C4, 12'h3C7, 12'h3C6, 12'h3C1, 12'h3C0, 12'h3C3, 12'h3C2}, 8, "R9");

    // R4, R7: length 4 sequential, latency 2.5
    phase = "R7";
    load_mode(2'b00, 13'h062);
    check(cfg_cas_x2 == 3'd5, "R4 latency 2.5", cfg_cas_x2, 5);
    kick(12'h0E);
    expect_burst('{12'h0E, 12'h0F, 12'h0C, 12'h0D, 0, 0, 0, 0}, 4, "R7");

    // R9: length 2 interleaved
    phase = "R9";
    load_mode(2'b00, 13'h069);
    kick(12'h207);
    expect_burst('{12'h207, 12'h206, 0, 0, 0, 0, 0, 0}, 2, "R9");

    // R5: DLL reset and reserved operating mode
    phase = "R5";
    load_mode(2'b00, 13'h121);
    check(cfg_dll_reset == 1'b1 && !cfg_error, "R5 dll reset", cfg_dll_reset, 1);
    load_mode(2'b00, 13'h221);
    check(cfg_error == 1'b1, "R5 reserved op", cfg_error, 1);

    // R6: start blocked while the error flag is set
    phase = "R6";
    kick(12'h011);
    repeat (3) begin
      check(beat_valid == 1'b0, "R6 no beats", beat_valid, 0);
      @(negedge clk);
    end
    load_mode(2'b00, 13'h020);
    check(cfg_burst_len == 4'd0 && cfg_error, "R2 reserved length", cfg_burst_len, 0);
    load_mode(2'b00, 13'h031);
    check(cfg_cas_x2 == 3'd0 && cfg_error, "R4 reserved latency", cfg_cas_x2, 0);
    kick(12'h011);
    check(beat_valid == 1'b0, "R6 no beats latency", beat_valid, 0);

    // R11: start during a burst ignored, start on last beat accepted
    phase = "R11";
    load_mode(2'b00, 13'h023);
    kick(12'h010);
    @(negedge clk); start = 1'b1; start_col = 12'h200;
    @(negedge clk); start = 1'b0;
    check(col_out == 12'h012, "R11 ignored start", col_out, 12'h012);
    repeat (5) @(negedge clk);
    check(beat_last == 1'b1 && col_out == 12'h017, "R11 last beat", col_out, 12'h017);
    start = 1'b1; start_col = 12'h0A3;
    @(negedge clk); start = 1'b0;
    check(beat_valid && col_out == 12'h0A3, "R11 back-to-back", col_out, 12'h0A3);

    // R12: mode load mid-burst does not change the running burst
    phase = "R12";
    repeat (8) @(negedge clk);
    kick(12'h040);
    @(negedge clk); mode_load = 1'b1; mode_addr = 13'h029;
    @(negedge clk); mode_load = 1'b0;
    check(beat_valid && !beat_last && col_out == 12'h042, "R12 length held", col_out, 12'h042);
    repeat (5) @(negedge clk);
    check(beat_last && col_out == 12'h047, "R12 eighth beat", col_out, 12'h047);
    kick(12'h053);
    expect_burst('{12'h053, 12'h052, 0, 0, 0, 0, 0, 0}, 2, "R12 new mode");

    repeat (4) @(negedge clk);
    cmp_on = 0;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule